// File: doc/BRIEF.md
# Triggered Waveform Capture Buffer

This block keeps a continuous record of an 8-bit sample stream that arrives at one sample per clock. Every sample goes into a circular history memory, and the write side never pauses. A trigger asks for a window of that history. The window begins a chosen number of samples before the trigger and covers a whole number of 8-sample frames. The block reads the window back one sample per clock, at the same rate as the stream, so the distance between the read point and the write point stays fixed and the read point can never be overtaken.

Each frame is tested against a baseline and a threshold. If no sample in the frame lies further than the threshold from the baseline, the frame is discarded. A frame that survives becomes three words in a channel FIFO: a header word, then two data words that each pack four samples. The FIFO drains through a 32-bit valid/ready port. The consumer may hold off `out_ready` for as long as it likes. While it does, the word on the port stays frozen. Readout of a window keeps running under back-pressure, and frames that find too little FIFO space are dropped and flagged.

Top module: `wave_capture`

## Requirements
- R1: A sample is stored on every clock after reset, whatever the trigger, readout or back-pressure state. The samples delivered for a window are exactly the input samples at those positions.
- R2: An accepted trigger starts its window at the sample that arrived `trig_back` samples before the sample present in the trigger cycle. A `trig_back` value above RING_DEPTH-2 (2046 by default) is treated as 2046.
- R3: A window spans `trig_frames`+1 frames of 8 consecutive samples. In data word 0 of a frame, sample 0 sits in bits [7:0] and sample 3 in bits [31:24]. Data word 1 carries samples 4 to 7 in the same order.
- R4: A frame is discarded when every sample s satisfies |s - `zs_base`| <= `zs_thr`. It is kept when at least one sample lies further away than that.
- R5: The header word of a kept frame holds, in bits [31:8], the low 24 bits of the frame's first sample index (samples are numbered from 0, starting with the first clock after reset). Bits [7:0] hold the trigger sequence number, which is 0 for the first accepted trigger after reset and goes up by one for each accepted trigger.
- R6: `out_first` is high with the header word and `out_last` is high with the second data word. Neither is high on the first data word.
- R7: When a frame that would be kept finds fewer than 3 free FIFO words, the whole frame is dropped and `overflow` is set. `overflow` stays set until `ovf_clr` is high. If a new drop and a clear happen in the same cycle, the flag stays set.
- R8: A trigger that arrives while a window is being read out has no effect on the window or on the sequence number. Instead, `missed_cnt` goes up by one and wraps at 256.
- R9: `out_valid` is high whenever the FIFO holds a word. A word is removed only on a clock where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_data`, `out_first` and `out_last` stay unchanged.
- R10: After reset, `out_valid` is low, `overflow` is low and `missed_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 8 | Incoming sample, one per clock |
| trig | input | 1 | Trigger request |
| trig_back | input | 12 | Look-back in samples, clamped to 2046 |
| trig_frames | input | 8 | Window length in frames, minus one |
| zs_base | input | 8 | Baseline used by zero suppression |
| zs_thr | input | 8 | Allowed distance from the baseline |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_data | output | 32 | FIFO word: a header or four packed samples |
| out_valid | output | 1 | A word is offered on the port |
| out_ready | input | 1 | The consumer accepts the word |
| out_first | output | 1 | The word is a frame header |
| out_last | output | 1 | The word is the last word of a frame |
| overflow | output | 1 | Sticky: a frame was lost for lack of space |
| missed_cnt | output | 8 | Count of triggers that arrived during a readout |

## Verification
Five stimulus patterns are used, and each one targets a different fault:
- A quiet stream stays within the threshold, including samples exactly at the threshold. A design that keeps frames on equality is caught here.
- A sparse stream has isolated samples one step outside the threshold, both above and below the baseline. This catches a one-sided or off-by-one distance test.
- A saturated stream, triggered with an oversized look-back, pins down both the clamp and the header time stamp.
- A sample ramp, triggered with zero look-back, reveals byte ordering and any slip of the read point.
- A long saturated run with the consumer stalled fills the FIFO. It shows that exactly the frames that fit survive, and it exercises the sticky flag and its clear.

The consumer alternates between always ready, randomly ready and stalled, so that hold-stable behaviour is tested both during readout and between windows.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  localparam int SMP_W           = 8;
  localparam int FRAME_N         = 8;
  localparam int WORD_SMP        = 4;
  localparam int WORD_W          = SMP_W * WORD_SMP;
  localparam int WORDS_PER_FRAME = FRAME_N / WORD_SMP;
  localparam int TS_W            = 24;
  localparam int SEQ_W           = 8;
  localparam int MISS_W          = 8;

  typedef struct packed {
    logic              first;
    logic              last;
    logic [WORD_W-1:0] data;
  } chan_word_t;
endpackage

// File: rtl/wcap_ring.sv
module wcap_ring
  import wcap_pkg::*;
#(
  parameter int RING_DEPTH = 2048
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SMP_W-1:0]              wr_data,
  input  logic [$clog2(RING_DEPTH)-1:0] rd_addr,
  output logic [SMP_W-1:0]              rd_data,
  output logic [TS_W-1:0]               wr_ts
);
  localparam int AW = $clog2(RING_DEPTH);

  logic [SMP_W-1:0] hist_mem [RING_DEPTH];
  logic [TS_W-1:0]  ts_q;

  // sample index of the value being written this cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    hist_mem[ts_q[AW-1:0]] <= wr_data;
  end

  assign rd_data = hist_mem[rd_addr];
  assign wr_ts   = ts_q;

  AST_TS_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    ts_q != '1 |=> ts_q == $past(ts_q) + 1'b1); // R1
endmodule

// File: rtl/wcap_chfifo.sv
module wcap_chfifo
  import wcap_pkg::*;
#(
  parameter int WORDS = 1024
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  chan_word_t                push_word,
  output logic                      out_valid,
  input  logic                      out_ready,
  output chan_word_t                out_word,
  output logic [$clog2(WORDS):0]    lvl
);
  localparam int AW = $clog2(WORDS);
  localparam int LW = AW + 1;

  chan_word_t     store [WORDS];
  logic [AW-1:0]  wp_q, rp_q;
  logic [LW-1:0]  cnt_q;
  logic           wr_en, rd_en;

  assign out_valid = (cnt_q != '0);
  assign rd_en     = out_valid && out_ready;
  assign wr_en     = push && (cnt_q != LW'(WORDS));
  assign out_word  = store[rp_q];
  assign lvl       = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wp_q] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_en) wp_q <= wp_q + 1'b1;
      if (rd_en) rp_q <= rp_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt_q < LW'(WORDS)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)); // R9
endmodule

// File: rtl/wcap_window.sv
module wcap_window
  import wcap_pkg::*;
#(
  parameter int RING_DEPTH = 2048,
  parameter int FIFO_WORDS = 1024,
  parameter int LEN_W      = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          trig,
  input  logic [$clog2(RING_DEPTH):0]   trig_back,
  input  logic [LEN_W-1:0]              trig_frames,
  input  logic [SMP_W-1:0]              zs_base,
  input  logic [SMP_W-1:0]              zs_thr,
  input  logic                          ovf_clr,
  input  logic [TS_W-1:0]               wr_ts,
  output logic [$clog2(RING_DEPTH)-1:0] rd_addr,
  input  logic [SMP_W-1:0]              rd_data,
  input  logic [$clog2(FIFO_WORDS):0]   fifo_lvl,
  output logic                          push,
  output chan_word_t                    push_word,
  output logic                          overflow,
  output logic [MISS_W-1:0]             missed_cnt
);
  localparam int AW       = $clog2(RING_DEPTH);
  localparam int BW       = AW + 1;
  localparam int IW       = $clog2(FRAME_N);
  localparam int PW       = $clog2(WORDS_PER_FRAME + 1);
  localparam int LW       = $clog2(FIFO_WORDS) + 1;
  localparam int MAX_BACK = RING_DEPTH - 2;
  localparam int NEED     = WORDS_PER_FRAME + 1;
  localparam int FV_W     = FRAME_N * SMP_W;

  logic                          busy_q;
  logic [TS_W-1:0]               rd_ts_q;
  logic [LEN_W-1:0]              frm_left_q;
  logic [IW-1:0]                 idx_q;
  logic [TS_W-1:0]               start_ts_q;
  logic [SEQ_W-1:0]              seq_q, cur_seq_q;
  logic [MISS_W-1:0]             missed_q;
  logic                          ovf_q;
  logic                          push_act;
  logic [PW-1:0]                 ph_q;
  logic [FV_W-1:0]               pend_vec;
  logic [TS_W-1:0]               pend_ts;
  logic [SEQ_W-1:0]              pend_seq;
  logic [(FRAME_N-1)*SMP_W-1:0]  smp_q;

  logic [BW-1:0]    back_c;
  logic [FV_W-1:0]  frame_vec;
  logic [FRAME_N-1:0] beyond;
  logic             frame_done, keep, room;

  assign back_c     = (trig_back > BW'(MAX_BACK)) ? BW'(MAX_BACK) : trig_back;
  assign frame_done = busy_q && (idx_q == IW'(FRAME_N - 1));
  assign keep       = |beyond;
  assign room       = fifo_lvl <= LW'(FIFO_WORDS - NEED);
  assign rd_addr    = rd_ts_q[AW-1:0];

  // assemble the frame: the last sample comes straight from the ring
  for (genvar gi = 0; gi < FRAME_N; gi++) begin : g_zs
    logic [SMP_W-1:0] s, dev;
    if (gi == FRAME_N - 1) begin : g_tail
      assign s = rd_data;
    end else begin : g_held
      assign s = smp_q[gi*SMP_W +: SMP_W];
      always_ff @(posedge clk) begin
        if (busy_q && idx_q == IW'(gi)) smp_q[gi*SMP_W +: SMP_W] <= rd_data;
      end
    end
    assign frame_vec[gi*SMP_W +: SMP_W] = s;
    assign dev        = (s >= zs_base) ? (s - zs_base) : (zs_base - s);
    assign beyond[gi] = dev > zs_thr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      rd_ts_q    <= '0;
      frm_left_q <= '0;
      idx_q      <= '0;
      start_ts_q <= '0;
      seq_q      <= '0;
      cur_seq_q  <= '0;
      missed_q   <= '0;
      ovf_q      <= 1'b0;
      push_act   <= 1'b0;
      ph_q       <= '0;
      pend_vec   <= '0;
      pend_ts    <= '0;
      pend_seq   <= '0;
    end else begin
      if (push_act) begin
        if (ph_q == PW'(WORDS_PER_FRAME)) begin
          push_act <= 1'b0;
          ph_q     <= '0;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end

      if (busy_q) begin
        rd_ts_q <= rd_ts_q + 1'b1;
        idx_q   <= frame_done ? '0 : idx_q + 1'b1;
        if (idx_q == '0) start_ts_q <= rd_ts_q;
        if (frame_done) begin
          if (keep && room) begin
            pend_vec <= frame_vec;
            pend_ts  <= start_ts_q;
            pend_seq <= cur_seq_q;
            push_act <= 1'b1;
            ph_q     <= '0;
          end
          if (frm_left_q == '0) busy_q <= 1'b0;
          else                  frm_left_q <= frm_left_q - 1'b1;
        end
        if (trig) missed_q <= missed_q + 1'b1;
      end else if (trig) begin
        busy_q     <= 1'b1;
        rd_ts_q    <= wr_ts - TS_W'(back_c);
        idx_q      <= '0;
        frm_left_q <= trig_frames;
        cur_seq_q  <= seq_q;
        seq_q      <= seq_q + 1'b1;
      end

      if (frame_done && keep && !room) ovf_q <= 1'b1;
      else if (ovf_clr)                ovf_q <= 1'b0;
    end
  end

  always_comb begin
    push_word.first = (ph_q == '0);
    push_word.last  = (ph_q == PW'(WORDS_PER_FRAME));
    if (ph_q == '0) push_word.data = {pend_ts, pend_seq};
    else            push_word.data = pend_vec[WORD_W*(int'(ph_q)-1) +: WORD_W];
  end

  assign push       = push_act;
  assign overflow   = ovf_q;
  assign missed_cnt = missed_q;

  AST_READ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (wr_ts - rd_ts_q) >= TS_W'(1) && (wr_ts - rd_ts_q) <= TS_W'(RING_DEPTH - 1)); // R2

  AST_MISSED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    trig && busy_q |=> missed_cnt == $past(missed_cnt) + 1'b1); // R8

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !ovf_clr |=> overflow); // R7

  AST_PUSH_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !push_act); // R3
endmodule

// File: rtl/wave_capture.sv
module wave_capture
  import wcap_pkg::*;
#(
  parameter int RING_DEPTH = 2048,
  parameter int FIFO_WORDS = 1024,
  parameter int LEN_W      = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [SMP_W-1:0]             smp_in,
  input  logic                         trig,
  input  logic [$clog2(RING_DEPTH):0]  trig_back,
  input  logic [LEN_W-1:0]             trig_frames,
  input  logic [SMP_W-1:0]             zs_base,
  input  logic [SMP_W-1:0]             zs_thr,
  input  logic                         ovf_clr,
  output logic [WORD_W-1:0]            out_data,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic                         out_first,
  output logic                         out_last,
  output logic                         overflow,
  output logic [MISS_W-1:0]            missed_cnt
);
  localparam int AW = $clog2(RING_DEPTH);
  localparam int LW = $clog2(FIFO_WORDS) + 1;

  logic [AW-1:0]    rd_addr;
  logic [SMP_W-1:0] rd_data;
  logic [TS_W-1:0]  wr_ts;
  logic [LW-1:0]    fifo_lvl;
  logic             push;
  chan_word_t       push_word, head_word;

  wcap_ring #(.RING_DEPTH(RING_DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .wr_data(smp_in),
    .rd_addr(rd_addr), .rd_data(rd_data), .wr_ts(wr_ts)
  );

  wcap_window #(.RING_DEPTH(RING_DEPTH), .FIFO_WORDS(FIFO_WORDS), .LEN_W(LEN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .trig(trig), .trig_back(trig_back),
    .trig_frames(trig_frames), .zs_base(zs_base), .zs_thr(zs_thr),
    .ovf_clr(ovf_clr), .wr_ts(wr_ts), .rd_addr(rd_addr), .rd_data(rd_data),
    .fifo_lvl(fifo_lvl), .push(push), .push_word(push_word),
    .overflow(overflow), .missed_cnt(missed_cnt)
  );

  wcap_chfifo #(.WORDS(FIFO_WORDS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(head_word),
    .lvl(fifo_lvl)
  );

  assign out_data  = head_word.data;
  assign out_first = head_word.first;
  assign out_last  = head_word.last;

  AST_MARK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_first && out_last)); // R6
endmodule

// File: tb/wave_capture_test.sv
module wave_capture_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [7:0]  d_smp = '0;
  logic        d_trig = 1'b0, d_clr = 1'b0, d_ready = 1'b0;
  logic [11:0] d_back = '0;
  logic [7:0]  d_len = '0, d_base = 8'd100, d_thr = 8'd2;
  logic [31:0] out_data;
  logic        out_valid, out_first, out_last, overflow;
  logic [7:0]  missed_cnt;

  wave_capture uut (
    .clk(clk), .rst_n(rst_n), .smp_in(d_smp), .trig(d_trig), .trig_back(d_back),
    .trig_frames(d_len), .zs_base(d_base), .zs_thr(d_thr), .ovf_clr(d_clr),
    .out_data(out_data), .out_valid(out_valid), .out_ready(d_ready),
    .out_first(out_first), .out_last(out_last), .overflow(overflow),
    .missed_cnt(missed_cnt)
  );

  // requested inputs for the next edge
  logic        n_trig = 1'b0, n_clr = 1'b0;
  logic [11:0] n_back = '0;
  logic [7:0]  n_len = '0, n_base = 8'd100, n_thr = 8'd2;
  int          smode = 0, rmode = 0;
  int unsigned lcg = 32'h1234_5678;

  int errors = 0, checks = 0;
  bit finished = 1'b0;

  // reference model state
  int m_ts = 0, m_rd = 0, m_left = 0, m_idx = 0, m_start = 0;
  int m_seq = 0, m_cur_seq = 0, m_missed = 0;
  bit m_busy = 0, m_ovf = 0;
  int m_fr [8];
  int hist [65536];
  logic [33:0] mq[$], mpend[$], got[$];
  logic        p_valid = 0, p_ready = 0;
  logic [31:0] p_data = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int rnd();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'(lcg >> 8);
  endfunction

  function automatic int gen_sample(int idx);
    case (smode)
      0: return 98 + (rnd() % 5);
      1: begin
        if (idx % 29 == 0) return ((idx / 29) % 2) ? 103 : 97;
        return 98 + (rnd() % 5);
      end
      3: return 200;
      default: return idx & 255;
    endcase
  endfunction

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic model_step();
    int old_lvl = mq.size();
    bit old_busy = m_busy;
    bit ovf_set = 0;
    bit keep;
    logic [33:0] w;
    bit do_push = mpend.size() > 0;
    bit do_pop = d_ready && mq.size() > 0;
    if (do_pop) void'(mq.pop_front());
    if (do_push) begin w = mpend.pop_front(); mq.push_back(w); end
    if (old_busy) begin
      m_fr[m_idx] = hist[m_rd % 65536];
      if (m_idx == 0) m_start = m_rd;
      if (m_idx == 7) begin
        keep = 0;
        for (int i = 0; i < 8; i++) if (absd(m_fr[i], int'(d_base)) > int'(d_thr)) keep = 1;
        if (keep) begin
          if (old_lvl <= 1021) begin
            mpend.push_back({2'b10, 24'(m_start), 8'(m_cur_seq)});
            mpend.push_back({2'b00, 8'(m_fr[3]), 8'(m_fr[2]), 8'(m_fr[1]), 8'(m_fr[0])});
            mpend.push_back({2'b01, 8'(m_fr[7]), 8'(m_fr[6]), 8'(m_fr[5]), 8'(m_fr[4])});
          end else ovf_set = 1;
        end
        if (m_left == 0) m_busy = 0; else m_left--;
        m_idx = 0;
      end else m_idx++;
      m_rd++;
      if (d_trig) m_missed = (m_missed + 1) % 256;
    end else if (d_trig) begin
      m_busy = 1;
      m_rd = m_ts - ((int'(d_back) > 2046) ? 2046 : int'(d_back));
      m_idx = 0;
      m_left = int'(d_len);
      m_cur_seq = m_seq;
      m_seq = (m_seq + 1) % 256;
    end
    if (ovf_set) m_ovf = 1; else if (d_clr) m_ovf = 0;
    hist[m_ts % 65536] = int'(d_smp);
    m_ts++;
  endtask

  task automatic tick();
    logic [33:0] ew;
    chk(out_valid == (mq.size() > 0), "R9", "valid", out_valid, mq.size() > 0);
    if (out_valid && mq.size() > 0) begin
      ew = mq[0];
      chk(out_data == ew[31:0], ew[33] ? "R5" : "R1/R3", "data", out_data, ew[31:0]);
      chk({out_first, out_last} == ew[33:32], "R6", "markers", {out_first, out_last}, ew[33:32]);
    end
    if (p_valid && !p_ready)
      chk(out_valid && out_data == p_data, "R9", "held word", out_data, p_data);
    chk(overflow == m_ovf, "R7", "overflow", overflow, m_ovf);
    chk(missed_cnt == 8'(m_missed), "R8", "missed", missed_cnt, m_missed);
    p_valid = out_valid;
    p_data  = out_data;
    // drive the next edge
    d_smp  = 8'(gen_sample(m_ts));
    d_trig = n_trig; d_back = n_back; d_len = n_len;
    d_base = n_base; d_thr = n_thr; d_clr = n_clr;
    d_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'(rnd() & 1) : 1'b0;
    p_ready = d_ready;
    if (out_valid && d_ready) got.push_back({out_first, out_last, out_data});
    model_step();
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic fire(int back, int len);
    n_trig = 1'b1; n_back = 12'(back); n_len = 8'(len);
    tick();
    n_trig = 1'b0;
  endtask

  initial begin : main
    int t0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10", "reset valid", out_valid, 0);
    chk(overflow == 1'b0, "R10", "reset overflow", overflow, 0);
    chk(missed_cnt == 8'd0, "R10", "reset missed", missed_cnt, 0);
    rst_n = 1'b1;

    // quiet stream: everything within threshold, incl. the edges
    smode = 0; run(2100);
    got.delete();
    fire(100, 3); run(60);
    chk(got.size() == 0, "R4", "quiet window words", got.size(), 0);

    // sparse excursions one step outside the threshold, random back-pressure
    smode = 1; run(2100);
    got.delete();
    rmode = 1;
    fire(500, 63); run(100);
    fire(10, 0); run(600);
    rmode = 0; run(200);
    chk(got.size() > 0 && got.size() % 3 == 0, "R4", "sparse window words", got.size(), 0);
    chk(missed_cnt == 8'd1, "R8", "trigger during readout", missed_cnt, 1);

    // saturated stream, oversized look-back
    smode = 3; run(2100);
    got.delete();
    t0 = m_ts;
    fire(4000, 1); run(40);
    chk(got.size() == 6, "R3", "two-frame window words", got.size(), 6);
    if (got.size() == 6) begin
      chk(got[0][31:8] == 24'(t0 - 2046), "R2", "clamped start", got[0][31:8], 24'(t0 - 2046));
      chk(got[0][7:0] == 8'd2, "R5", "sequence number", got[0][7:0], 2);
      chk(got[0][33:32] == 2'b10 && got[2][33:32] == 2'b01, "R6", "frame marks",
          {got[0][33:32], got[2][33:32]}, 6'h09);
    end

    // ramp with zero look-back
    smode = 4; n_base = 8'd0; n_thr = 8'd0; run(20);
    got.delete();
    t0 = m_ts;
    fire(0, 0); run(30);
    chk(got.size() == 3, "R3", "one-frame window words", got.size(), 3);
    if (got.size() == 3) begin
      chk(got[0][31:8] == 24'(t0), "R2", "zero look-back start", got[0][31:8], 24'(t0));
      chk(got[0][7:0] == 8'd3, "R5", "sequence after ramp", got[0][7:0], 3);
      chk(got[1][31:0] == {8'(t0+3), 8'(t0+2), 8'(t0+1), 8'(t0)}, "R1", "packed ramp",
          got[1][31:0], {8'(t0+3), 8'(t0+2), 8'(t0+1), 8'(t0)});
    end

    // fill the FIFO with the consumer stalled
    smode = 3; n_base = 8'd100; n_thr = 8'd2; run(20);
    got.delete();
    rmode = 2;
    fire(0, 255); run(2070);
    fire(0, 255); run(2070);
    chk(overflow == 1'b1, "R7", "overflow after flood", overflow, 1);
    n_clr = 1'b1; tick(); n_clr = 1'b0; tick();
    chk(overflow == 1'b0, "R7", "overflow cleared", overflow, 0);
    rmode = 0; run(1100);
    chk(got.size() == 1023, "R7", "words kept under flood", got.size(), 1023);
    run(10);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule